// File: doc/BRIEF.md
# Ternary Cascaded-Bridge Level Modulator

This block sits between a level reference and three series-connected H-bridge cells whose DC supplies are weighted 1, 3 and 9. Together the cells can put out any of 27 staircase steps, from -13 to +13. When a sample strobe arrives, the block takes a signed target level and clamps it to that range. It then splits the level into one balanced-ternary digit per cell, where each digit is +1, -1 or 0, so that the weighted sum of the digits equals the level.

Each digit is turned into the four gate drives of its cell. A cell whose digit changes has all four of its gates switched off for a fixed number of dead-time cycles before the new pattern is applied. Cells whose digit does not change keep driving their gates without interruption. A busy flag stays high for as long as any cell is inside its dead-time window. The block uses an active-low asynchronous reset.

Top module: `ternary_bridge_mod`

## Requirements
- R1: While reset is active and in the cycle after it is released, every cell drives its zero pattern, so `gate_o` is 12'hAAA, and `busy_o` is low.
- R2: Cell k (weight 3^k) drives `gate_o[4k+3:4k]` with bit0 = leg A high, bit1 = leg A low, bit2 = leg B high and bit3 = leg B low. The patterns are: digit +1 gives 4'b1001, digit -1 gives 4'b0110, and digit 0 gives 4'b1010.
- R3: Once settled, the digits (d9, d3, d1) satisfy 9·d9 + 3·d3 + d1 = level. Each digit is in {-1, 0, +1}. Examples: 2 gives (0, +1, -1), 5 gives (+1, -1, -1), 8 gives (+1, 0, -1), 11 gives (+1, +1, -1) and 13 gives (+1, +1, +1).
- R4: A negative level uses the negated digits of its magnitude. Level 0 puts every cell at digit 0.
- R5: A level above +13 is treated as +13, and a level below -13 is treated as -13.
- R6: A strobe that changes a cell's digit turns off all four gates of that cell for exactly DEAD_CYCLES cycles. The cell's new pattern appears on the following cycle.
- R7: A cell whose digit is unchanged by a strobe keeps its gates steady through the whole update.
- R8: Without `sample_i`, changes on `level_i` have no effect on `gate_o`.
- R9: `busy_o` is high exactly while at least one cell is in its dead-time window.
- R10: The high and low switch of one leg are never on together.
- R11: A strobe that changes a cell's target while that cell is already in dead time restarts the cell's full dead-time window, counted from that strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Strobe that latches `level_i` |
| level_i | input | LVL_W (6) | Signed target level |
| gate_o | output | 4·N_CELLS (12) | Gate drives, four per cell |
| busy_o | output | 1 | High while any cell is in dead time |

## Verification
The bench builds the block with the default three cells and a 6-bit level input, which lets it drive levels out to ±31 and so reach the clamp at both ends. It sets DEAD_CYCLES to 3. That is long enough to tell a single-cycle gap apart from a full window, and long enough to land a second strobe inside a running window and see the window restart. Random levels from -20 to +20 mix changes of one, two and three cells in a single update.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
  typedef enum logic [1:0] {
    DIG_OFF = 2'b00,
    DIG_POS = 2'b01,
    DIG_NEG = 2'b11
  } digit_e;

  // gate nibble: {b_lo, b_hi, a_lo, a_hi}
  localparam logic [3:0] GATE_POS  = 4'b1001;
  localparam logic [3:0] GATE_NEG  = 4'b0110;
  localparam logic [3:0] GATE_ZERO = 4'b1010;
  localparam logic [3:0] GATE_NONE = 4'b0000;

  function automatic logic [3:0] digit_to_gates(logic [1:0] d);
    case (d)
      DIG_POS: return GATE_POS;
      DIG_NEG: return GATE_NEG;
      default: return GATE_ZERO;
    endcase
  endfunction

  function automatic int digit_value(logic [1:0] d);
    case (d)
      DIG_POS: return 1;
      DIG_NEG: return -1;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/tbm_decomp.sv
module tbm_decomp import tbm_pkg::*; #(
  parameter int N_CELLS = 3,
  parameter int LVL_W   = 6
) (
  input  logic signed [LVL_W-1:0]   level_i,
  output logic [N_CELLS-1:0][1:0]   digit_o
);
  localparam int LVL_MAX = (3 ** N_CELLS - 1) / 2;

  int  lvl;
  int  mag;
  logic neg;

  always_comb begin
    lvl = int'(level_i);
    if (lvl > LVL_MAX)  lvl = LVL_MAX;
    if (lvl < -LVL_MAX) lvl = -LVL_MAX;
    neg = (lvl < 0);
    mag = neg ? -lvl : lvl;
    for (int k = 0; k < N_CELLS; k++) begin
      case (mag % 3)
        1: begin
          digit_o[k] = neg ? DIG_NEG : DIG_POS;
          mag = (mag - 1) / 3;
        end
        2: begin
          digit_o[k] = neg ? DIG_POS : DIG_NEG;
          mag = (mag + 1) / 3;
        end
        default: begin
          digit_o[k] = DIG_OFF;
          mag = mag / 3;
        end
      endcase
    end
  end

  int wsum;
  int wt;
  always_comb begin
    wsum = 0;
    wt   = 1;
    for (int k = 0; k < N_CELLS; k++) begin
      wsum = wsum + wt * digit_value(digit_o[k]);
      wt   = wt * 3;
    end
    assert_digit_sum_R3: assert (wsum == lvl);
  end
endmodule

// File: rtl/tbm_cell.sv
module tbm_cell import tbm_pkg::*; #(
  parameter int DEAD_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [1:0] digit_i,
  output logic [3:0] gates_o,
  output logic       busy_o
);
  localparam int CNT_W = (DEAD_CYCLES > 0) ? $clog2(DEAD_CYCLES + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DEAD_CYCLES);

  logic [1:0]       tgt_q, app_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= DIG_OFF;
      app_q <= DIG_OFF;
      cnt_q <= '0;
    end else begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) app_q <= tgt_q;
      end
      // changed target restarts the off window
      if (load_i && digit_i != tgt_q) begin
        tgt_q <= digit_i;
        if (DEAD_CYCLES == 0) app_q <= digit_i;
        else                  cnt_q <= CNT_LOAD;
      end
    end
  end

  assign busy_o  = (cnt_q != '0);
  assign gates_o = busy_o ? GATE_NONE : digit_to_gates(app_q);

  assert_no_shoot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gates_o[0] && gates_o[1]) && !(gates_o[2] && gates_o[3]));

  assert_break_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gates_o != GATE_NONE && $past(gates_o) != GATE_NONE) |-> $stable(gates_o));

  assert_hold_target_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(tgt_q));
endmodule

// File: rtl/ternary_bridge_mod.sv
module ternary_bridge_mod import tbm_pkg::*; #(
  parameter int N_CELLS     = 3,
  parameter int LVL_W       = 6,
  parameter int DEAD_CYCLES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sample_i,
  input  logic signed [LVL_W-1:0] level_i,
  output logic [4*N_CELLS-1:0]    gate_o,
  output logic                    busy_o
);
  logic [N_CELLS-1:0][1:0] digit;
  logic [N_CELLS-1:0]      cell_busy;

  tbm_decomp #(.N_CELLS(N_CELLS), .LVL_W(LVL_W)) u_decomp (
    .level_i(level_i),
    .digit_o(digit)
  );

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    tbm_cell #(.DEAD_CYCLES(DEAD_CYCLES)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (sample_i),
      .digit_i(digit[k]),
      .gates_o(gate_o[4*k +: 4]),
      .busy_o (cell_busy[k])
    );
  end

  assign busy_o = |cell_busy;

  logic any_off;
  always_comb begin
    any_off = 1'b0;
    for (int k = 0; k < N_CELLS; k++)
      if (gate_o[4*k +: 4] == GATE_NONE) any_off = 1'b1;
  end

  assert_busy_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == any_off);
endmodule

// File: tb/tb_ternary_bridge_mod.sv
`timescale 1ns/1ps
module tb_ternary_bridge_mod;
  localparam int DEAD = 3;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              sample_i = 1'b0;
  logic signed [5:0] level_i = '0;
  logic [11:0]       gate_o;
  logic              busy_o;

  int n_run  = 0;
  int n_fail = 0;
  logic [11:0] cur_exp;

  always #2.5 clk = ~clk;

  ternary_bridge_mod #(.N_CELLS(3), .LVL_W(6), .DEAD_CYCLES(DEAD)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i),
    .level_i(level_i), .gate_o(gate_o), .busy_o(busy_o)
  );

  function automatic logic [3:0] enc(int d);
    if (d > 0) return 4'b1001;
    if (d < 0) return 4'b0110;
    return 4'b1010;
  endfunction

  // brute-force search over all digit triples
  function automatic logic [11:0] exp_gates(int v);
    int c = (v > 13) ? 13 : ((v < -13) ? -13 : v);
    for (int a = -1; a <= 1; a++)
      for (int b = -1; b <= 1; b++)
        for (int e = -1; e <= 1; e++)
          if (9*a + 3*b + e == c) return {enc(a), enc(b), enc(e)};
    return 12'hFFF;
  endfunction

  function automatic logic [11:0] dead_view(logic [11:0] old_g, logic [11:0] new_g);
    logic [11:0] r;
    for (int k = 0; k < 3; k++)
      r[4*k +: 4] = (old_g[4*k +: 4] != new_g[4*k +: 4]) ? 4'b0 : old_g[4*k +: 4];
    return r;
  endfunction

  function automatic bit legs_ok(logic [11:0] g);
    for (int k = 0; k < 6; k++)
      if (g[2*k] && g[2*k+1]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // assumes called just after a negedge with the block idle
  task automatic apply(int v, string req);
    logic [11:0] nxt = exp_gates(v);
    level_i  = 6'(v);
    sample_i = 1'b1;
    @(negedge clk);
    sample_i = 1'b0;
    for (int i = 0; i < DEAD; i++) begin
      chk({req, " R6 R7 dead gates"}, gate_o, dead_view(cur_exp, nxt));
      chk("R9 busy in window", {11'b0, busy_o}, {11'b0, (nxt != cur_exp)});
      chk("R10 legs", {11'b0, legs_ok(gate_o)}, 12'd1);
      @(negedge clk);
    end
    chk({req, " R3 settled"}, gate_o, nxt);
    chk("R9 busy cleared", {11'b0, busy_o}, 12'd0);
    cur_exp = nxt;
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h00C0FFEE);
    repeat (3) @(negedge clk);
    chk("R1 reset gates", gate_o, 12'hAAA);
    chk("R1 reset busy", {11'b0, busy_o}, 12'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release", gate_o, 12'hAAA);
    cur_exp = 12'hAAA;

    apply(1, "R2");
    chk("R2 pos nibble", {8'b0, gate_o[3:0]}, 12'h009);
    chk("R2 zero nibble", {4'b0, gate_o[11:4]}, 12'h0AA);
    apply(-1, "R2");
    chk("R2 neg nibble", {8'b0, gate_o[3:0]}, 12'h006);
    apply(2, "R3"); chk("R3 level 2", gate_o, {4'b1010, 4'b1001, 4'b0110});
    apply(5, "R3"); chk("R3 level 5", gate_o, {4'b1001, 4'b0110, 4'b0110});
    apply(8, "R3"); chk("R3 level 8", gate_o, {4'b1001, 4'b1010, 4'b0110});
    apply(4, "R3");
    apply(11, "R3");
    apply(13, "R3"); chk("R3 level 13", gate_o, 12'h999);
    apply(-13, "R4"); chk("R4 level -13", gate_o, 12'h666);
    apply(-5, "R4"); chk("R4 level -5", gate_o, {4'b0110, 4'b1001, 4'b1001});
    apply(0, "R4"); chk("R4 level 0", gate_o, 12'hAAA);
    apply(31, "R5"); chk("R5 clamp high", gate_o, 12'h999);
    apply(-32, "R5"); chk("R5 clamp low", gate_o, 12'h666);
    apply(20, "R5");
    apply(13, "R5 R7 no change");

    // R8: level moves without strobe
    level_i = -6'sd7;
    repeat (5) begin
      @(negedge clk);
      chk("R8 no strobe", gate_o, cur_exp);
      chk("R8 busy idle", {11'b0, busy_o}, 12'd0);
    end

    // R11: restart of a running window
    apply(0, "R11 prep");
    level_i = 6'sd1; sample_i = 1'b1;
    @(negedge clk);
    chk("R11 first gap", gate_o, 12'hAA0);
    level_i = -6'sd1;
    @(negedge clk);
    sample_i = 1'b0;
    for (int i = 0; i < DEAD; i++) begin
      chk("R11 restarted gap", gate_o, 12'hAA0);
      chk("R11 busy", {11'b0, busy_o}, 12'd1);
      @(negedge clk);
    end
    chk("R11 final", gate_o, 12'hAA6);
    cur_exp = 12'hAA6;

    for (int n = 0; n < 300; n++) begin
      int v = int'($urandom_range(40, 0)) - 20;
      apply(v, "R3 R5 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule